// File: doc/BRIEF.md
# Event Run-Length Watermark Monitor

This block watches a set of event lines and, for each line, counts how many consecutive clock cycles the line has stayed high. A per-line high-water mark keeps the longest run seen since reset. Each line has a threshold supplied from outside. When a run climbs above that threshold, a sticky per-line interrupt bit is raised and held until reset. A combined interrupt and a one-cycle-delayed copy of it are also provided.

The block also guards its own state against single-event upsets. A run counter can legally only hold, step up by one or clear to zero, so every cycle a checker compares the counter with the value it held one cycle earlier. The high-water mark is kept in two identical copies that are compared continuously. Either kind of violation latches a dedicated error interrupt. A single enable input freezes all counting, watermark and interrupt state while it is low.

Top module: `evt_run_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, all run counters, watermarks, interrupt bits, the delayed interrupt and the error interrupt clear to zero on that edge.
- R2: With `enable` high, each edge at which a line is sampled high adds one to that line's run, and each edge at which it is sampled low clears the run to zero. `wm_o` slice i (bits i*CNT_W upward) shows the new value after the same edge whenever it exceeds the old watermark.
- R3: A watermark never decreases, so a run shorter than an earlier one leaves it unchanged.
- R4: A run saturates at 2^CNT_W-1 and does not wrap, and the watermark saturates with it.
- R5: `irq_vec_o[i]` sets on the edge where line i's run becomes strictly greater than `thr_i` slice i. It then stays set until reset.
- R6: `irq_o` is high exactly when any bit of `irq_vec_o` is high.
- R7: On each edge with `enable` high, `irq_prev_o` takes the value `irq_o` had just before that edge. With `enable` low it holds.
- R8: While `enable` is low, runs, watermarks and interrupt bits hold, whatever the lines do. Counting resumes from the held run once `enable` returns.
- R9: A run counter value that is neither its previous value, that value plus one, nor zero sets `err_irq_o` one edge later. The error stays set until reset.
- R10: Any disagreement between the two copies of a watermark sets `err_irq_o` one edge later. The error stays set until reset.
- R11: Legal traffic, including saturation and enable pauses, never raises `err_irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Gates all counting and interrupt updates |
| evt_i | input | N_EVT | Event lines, one bit per monitored event |
| thr_i | input | N_EVT*CNT_W | Per-line run threshold, slice i at bits i*CNT_W |
| irq_vec_o | output | N_EVT | Sticky per-line over-threshold interrupt |
| irq_o | output | 1 | OR of all interrupt bits |
| irq_prev_o | output | 1 | `irq_o` as it was one enabled cycle earlier |
| wm_o | output | N_EVT*CNT_W | Per-line longest-run watermark, slice i at bits i*CNT_W |
| err_irq_o | output | 1 | Sticky self-check error interrupt |

## Verification
Watermarks and interrupt bits change on the same edge that samples the event level, and `irq_o` follows them without a further register. `irq_prev_o` lags by one more enabled edge. An injected upset shows on `err_irq_o` one edge after it appears. The bench drives inputs on the falling edge and compares every output at the following falling edge, against a model it steps once per rising edge. That way each result is read in the first cycle it is due. Directed tests force a run counter and one watermark copy to reach the two error paths.

// File: rtl/evt_run_pkg.sv
package evt_run_pkg;

    localparam int unsigned DEF_N_EVT = 4;
    localparam int unsigned DEF_CNT_W = 8;

    // Classification of the worst fault seen in a lane during one cycle
    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_STEP = 2'd1,
        FLT_COPY = 2'd2
    } fault_e;

    // Flags a lane hands to the top level
    typedef struct packed {
        logic irq;
        logic err;
    } lane_flags_t;

endpackage

// File: rtl/evt_upset_chk.sv
module evt_upset_chk
    import evt_run_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] run_q,
    input  logic [CNT_W-1:0] wm_a,
    input  logic [CNT_W-1:0] wm_b,
    output logic             err_o
);
    logic [CNT_W-1:0] run_seen_q;
    logic [CNT_W:0]   run_next_ok;
    logic             step_ok;
    fault_e           fault;
    logic             err_q;

    assign run_next_ok = {1'b0, run_seen_q} + {{CNT_W{1'b0}}, 1'b1};
    assign step_ok = (run_q == run_seen_q) || ({1'b0, run_q} == run_next_ok) ||
                     (run_q == '0);

    always_comb begin
        if (wm_a != wm_b)  fault = FLT_COPY;
        else if (!step_ok) fault = FLT_STEP;
        else               fault = FLT_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_seen_q <= '0;
            err_q      <= 1'b0;
        end else begin
            run_seen_q <= run_q;
            err_q      <= err_q | (fault != FLT_NONE);
        end
    end

    assign err_o = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q); // R9

endmodule

// File: rtl/evt_run_lane.sv
module evt_run_lane
    import evt_run_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             evt,
    input  logic [CNT_W-1:0] thr,
    output logic [CNT_W-1:0] wm,
    output lane_flags_t      flags
);
    localparam logic [CNT_W-1:0] RUN_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_d;
    logic [CNT_W-1:0] wm_a;
    logic [CNT_W-1:0] wm_b;
    logic             irq_q;
    logic             chk_err;

    always_comb begin
        if (!enable)               run_d = run_q;
        else if (!evt)             run_d = '0;
        else if (run_q == RUN_MAX) run_d = run_q;
        else                       run_d = run_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            wm_a  <= '0;
            wm_b  <= '0;
            irq_q <= 1'b0;
        end else if (enable) begin
            run_q <= run_d;
            if (run_d > wm_a) wm_a <= run_d;
            if (run_d > wm_b) wm_b <= run_d;
            irq_q <= irq_q | (run_d > thr);
        end
    end

    evt_upset_chk #(.CNT_W(CNT_W)) u_chk (
        .clk   (clk),
        .rst   (rst),
        .run_q (run_q),
        .wm_a  (wm_a),
        .wm_b  (wm_b),
        .err_o (chk_err)
    );

    assign wm        = wm_a;
    assign flags.irq = irq_q;
    assign flags.err = chk_err;

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> irq_q); // R5
    AST_WM_MONO: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (wm_a >= $past(wm_a))); // R3
    AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !enable |=> ($stable(wm_a) && $stable(irq_q))); // R8

endmodule

// File: rtl/evt_run_monitor.sv
module evt_run_monitor
    import evt_run_pkg::*;
#(
    parameter int unsigned N_EVT = DEF_N_EVT,
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   enable,
    input  logic [N_EVT-1:0]       evt_i,
    input  logic [N_EVT*CNT_W-1:0] thr_i,
    output logic [N_EVT-1:0]       irq_vec_o,
    output logic                   irq_o,
    output logic                   irq_prev_o,
    output logic [N_EVT*CNT_W-1:0] wm_o,
    output logic                   err_irq_o
);
    lane_flags_t [N_EVT-1:0] lane_flags;
    logic [N_EVT-1:0]        lane_err;
    logic                    irq_prev_q;

    for (genvar i = 0; i < N_EVT; i++) begin : g_lane
        evt_run_lane #(.CNT_W(CNT_W)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .enable (enable),
            .evt    (evt_i[i]),
            .thr    (thr_i[i*CNT_W +: CNT_W]),
            .wm     (wm_o[i*CNT_W +: CNT_W]),
            .flags  (lane_flags[i])
        );
        assign irq_vec_o[i] = lane_flags[i].irq;
        assign lane_err[i]  = lane_flags[i].err;
    end

    assign irq_o     = |irq_vec_o;
    assign err_irq_o = |lane_err;

    always_ff @(posedge clk) begin
        if (rst)         irq_prev_q <= 1'b0;
        else if (enable) irq_prev_q <= irq_o;
    end

    assign irq_prev_o = irq_prev_q;

    AST_PREV_IRQ: assert property (@(posedge clk) disable iff (rst)
        enable |=> (irq_prev_o == $past(irq_o))); // R7
    AST_PREV_HOLD: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(irq_prev_o)); // R7

endmodule

// File: tb/evt_run_monitor_tb.sv
module evt_run_monitor_tb;
    localparam int N = 4;
    localparam int W = 8;
    localparam int MAXV = (1 << W) - 1;
    localparam int NSTIM = 24;
    // bit 4 = enable, bits 3:0 = event lines
    localparam logic [4:0] STIM [NSTIM] = '{
        5'h1F, 5'h1F, 5'h1F, 5'h10, 5'h13, 5'h13, 5'h13, 5'h13,
        5'h0C, 5'h0C, 5'h1C, 5'h1C, 5'h14, 5'h14, 5'h14, 5'h14,
        5'h04, 5'h14, 5'h18, 5'h18, 5'h10, 5'h11, 5'h11, 5'h10
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic [N-1:0] evt_i = '0;
    logic [N*W-1:0] thr_i;
    logic [N-1:0] irq_vec_o;
    logic irq_o, irq_prev_o, err_irq_o;
    logic [N*W-1:0] wm_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_run [N];
    int m_wm [N];
    int m_thr [N];
    logic [N-1:0] m_vec;
    logic m_prev;

    always #5 clk = ~clk;

    evt_run_monitor #(.N_EVT(N), .CNT_W(W)) u_dut (
        .clk(clk), .rst(rst), .enable(enable), .evt_i(evt_i), .thr_i(thr_i),
        .irq_vec_o(irq_vec_o), .irq_o(irq_o), .irq_prev_o(irq_prev_o),
        .wm_o(wm_o), .err_irq_o(err_irq_o)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_zero();
        for (int i = 0; i < N; i++) begin
            m_run[i] = 0;
            m_wm[i] = 0;
        end
        m_vec = '0;
        m_prev = 1'b0;
    endtask

    task automatic model_step(logic en, logic [N-1:0] ev);
        logic any_old;
        any_old = |m_vec;
        if (en) begin
            for (int i = 0; i < N; i++) begin
                if (!ev[i]) m_run[i] = 0;
                else if (m_run[i] < MAXV) m_run[i] = m_run[i] + 1;
                if (m_run[i] > m_wm[i]) m_wm[i] = m_run[i];
                if (m_run[i] > m_thr[i]) m_vec[i] = 1'b1;
            end
            m_prev = any_old;
        end
    endtask

    // apply inputs at a falling edge, advance one full cycle
    task automatic cycle(logic en, logic [N-1:0] ev);
        enable = en;
        evt_i = ev;
        model_step(en, ev);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic compare_all(string tag, int exp_err);
        for (int i = 0; i < N; i++)
            check({tag, " R2 R3 wm"}, int'(wm_o[i*W +: W]), m_wm[i]);
        check({tag, " R5 vec"}, int'(irq_vec_o), int'(m_vec));
        check({tag, " R6 irq"}, int'(irq_o), int'(|m_vec));
        check({tag, " R7 prev"}, int'(irq_prev_o), int'(m_prev));
        check({tag, " R11 err"}, int'(err_irq_o), exp_err);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        enable = 1'b0;
        evt_i = '0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_zero();
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_thr[0] = 2; m_thr[1] = 0; m_thr[2] = 5; m_thr[3] = 3;
        for (int i = 0; i < N; i++) thr_i[i*W +: W] = W'(m_thr[i]);
        @(negedge clk);
        // R1: reset state, after activity
        do_reset();
        cycle(1'b1, 4'hF);
        cycle(1'b1, 4'hF);
        do_reset();
        compare_all("R1 reset", 0);
        check("R1 wm0", int'(wm_o[0 +: W]), 0);
        check("R1 vec", int'(irq_vec_o), 0);

        // table walk against model
        for (int k = 0; k < NSTIM; k++) begin
            cycle(STIM[k][4], STIM[k][3:0]);
            compare_all("table", 0);
        end

        // R8: freeze while disabled, resume from held run
        do_reset();
        cycle(1'b1, 4'h1);
        cycle(1'b1, 4'h1);
        check("R2 wm0 after two", int'(wm_o[0 +: W]), 2);
        check("R5 not yet over", int'(irq_vec_o[0]), 0);
        cycle(1'b1, 4'h1);
        check("R5 bit0 set", int'(irq_vec_o[0]), 1);
        check("R7 prev lags", int'(irq_prev_o), 0);
        for (int k = 0; k < 4; k++) cycle(1'b0, 4'hF);
        check("R8 wm0 frozen", int'(wm_o[0 +: W]), 3);
        check("R8 vec frozen", int'(irq_vec_o), 1);
        check("R8 prev held", int'(irq_prev_o), 0);
        cycle(1'b1, 4'h1);
        check("R8 resume run", int'(wm_o[0 +: W]), 4);
        check("R7 prev now", int'(irq_prev_o), 1);
        // R3: shorter run keeps watermark
        cycle(1'b1, 4'h0);
        cycle(1'b1, 4'h1);
        cycle(1'b1, 4'h0);
        check("R3 wm kept", int'(wm_o[0 +: W]), 4);
        check("R5 sticky", int'(irq_vec_o[0]), 1);
        compare_all("R3 R8 tail", 0);

        // R4: saturation on lane 2
        do_reset();
        for (int k = 0; k < MAXV + 6; k++) cycle(1'b1, 4'h4);
        check("R4 wm saturates", int'(wm_o[2*W +: W]), MAXV);
        check("R11 no err at saturation", int'(err_irq_o), 0);
        compare_all("R4", 0);

        // R9: illegal run step on lane 0 (0 -> 50)
        do_reset();
        cycle(1'b1, 4'h0);
        force u_dut.g_lane[0].u_lane.run_q = 8'd50;
        @(posedge clk);
        @(negedge clk);
        release u_dut.g_lane[0].u_lane.run_q;
        check("R9 err set", int'(err_irq_o), 1);
        for (int k = 0; k < 3; k++) cycle(1'b1, 4'h0);
        check("R9 err sticky", int'(err_irq_o), 1);
        do_reset();
        check("R1 err cleared", int'(err_irq_o), 0);

        // R10: watermark copy mismatch on lane 3
        cycle(1'b1, 4'h0);
        force u_dut.g_lane[3].u_lane.wm_b = 8'd7;
        @(posedge clk);
        @(negedge clk);
        release u_dut.g_lane[3].u_lane.wm_b;
        check("R10 err set", int'(err_irq_o), 1);
        check("R10 visible wm unchanged", int'(wm_o[3*W +: W]), 0);
        do_reset();
        check("R10 err cleared by reset", int'(err_irq_o), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule